// File: doc/BRIEF.md
# Quad-Probe Table-Driven Trigger Engine

This block watches sixteen logic-analyser probes, grouped as four quads of four, and raises a sticky trigger flag when a programmed condition is met. The condition has two parts. A level part matches a value under a mask. An edge part follows up to two single probes and fires on a chosen rise or fall of either one. Each part is held in small truth tables. Every quad owns one 16-entry table per table set, and the quad's four probe bits select the entry. The edge part uses a 16-entry glue table. That table is indexed by the old and new values of both followed probes.

Software fills the tables through a narrow register port, one column at a time. It first writes a 16-bit column word holding bit i of every table. It then writes a commit code that names column i, and this must happen while programming mode is active. During programming the trigger cannot fire, but the edge history keeps running. The flag stays set until the next acquisition restart (`arm`).

Top module: `quad_lut_trigger`

## Requirements
- R1: After reset `trig` is low. The level tables and the glue table hold all ones and the selector tables hold zeros, so with no programming the first enabled sample sets `trig`.
- R2: The level result is the AND, over the four quads, of the level-table bit addressed by that quad's probe nibble. Quad q uses probes 4q+3..4q, and the lowest probe goes to the lowest address bit.
- R3: Selector n's current value is the AND of its four quad lookups. The edge result is glue-table bit {prev1, cur1, prev0, cur0}, so bits 2n and 2n+1 of the index are selector n's current and previous values. A rise is previous 0 with current 1, and a fall is previous 1 with current 0.
- R4: On a cycle with `smp_en` high and `prog_en` low, `trig` goes high one clock later if both the level result and the edge result are 1.
- R5: Once high, `trig` stays high until `arm` is sampled high, and `arm` then clears it one clock later. `arm` wins over a matching sample in the same cycle.
- R6: Both selector history bits take the current selector values on every `smp_en` cycle, whether or not programming mode is active. They hold in all other cycles, even when probes change.
- R7: `col_wr` loads the column word. A commit is `ctl_wr` with `ctl_data[7:4]` = 4'h3 while `prog_en` is high. It writes entry `ctl_data[3:0]` of every table from the column word: low byte bits 3..0 go to the level quads 0..3, bit 4 to the glue table, high byte bits 3..0 to the selector 0 quads and high byte bits 7..4 to the selector 1 quads. Bits 7..5 of the low byte have no effect.
- R8: A `ctl_wr` with `prog_en` low, or with an upper nibble other than 4'h3, leaves every table unchanged.
- R9: While `prog_en` is high, `trig` does not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probes | input | 16 | Probe sample, quad q on bits 4q+3..4q |
| smp_en | input | 1 | Sample valid for this cycle |
| arm | input | 1 | Acquisition restart, clears the trigger flag |
| prog_en | input | 1 | Table programming mode |
| col_wr | input | 1 | Load the column word |
| col_data | input | 16 | Column word, bit i of every table |
| ctl_wr | input | 1 | Control write strobe |
| ctl_data | input | 8 | Control code, 0x30 plus column index to commit |
| trig | output | 1 | Sticky trigger flag |

## Verification
The bench uses the default geometry: four quads of four probes, 16-entry tables and a 16-entry glue table. At this size an 8-probe masked value can be swept through all 256 settings, and every old/new pairing of the two followed probes comes up many times in a few hundred samples. Expected trigger values come from tables that the bench builds arithmetically from value, mask and edge choices. The bench also keeps its own record of the selector history, including samples taken during programming and probe changes in cycles without a sample.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int QUAD_W    = 4;
  localparam int NUM_QUADS = 4;
  localparam int PROBE_W   = QUAD_W * NUM_QUADS;
  localparam int TBL_D     = 1 << QUAD_W;
  localparam int GLUE_IW   = 4;
  localparam int GLUE_D    = 1 << GLUE_IW;
  localparam int NUM_SETS  = 3;
  localparam int COL_W     = 16;
  localparam int CTL_W     = 8;
  localparam int GLUE_BIT  = 4;
  localparam int SPARE_LSB = 5;
  localparam int SPARE_W   = 3;
  localparam int SEL0_LSB  = 8;
  localparam int SEL1_LSB  = 12;
  localparam logic [3:0] CMD_COMMIT = 4'h3;

  typedef logic [TBL_D-1:0]  tbl_t;
  typedef tbl_t [NUM_QUADS-1:0] qset_t;
  typedef logic [GLUE_D-1:0] glue_t;
endpackage

// File: rtl/trig_lut_store.sv
module trig_lut_store
  import trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_en,
  input  logic             col_wr,
  input  logic [COL_W-1:0] col_data,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_data,
  output qset_t            lvl_tab,
  output qset_t            sel0_tab,
  output qset_t            sel1_tab,
  output glue_t            glue_tab
);
  logic [COL_W-1:0]   stage_q, stage_d;
  qset_t              lvl_q, lvl_d, s0_q, s0_d, s1_q, s1_d;
  glue_t              glue_q, glue_d;
  logic               commit;
  logic [QUAD_W-1:0]  col_idx;
  logic [SPARE_W-1:0] spare_unused;

  assign spare_unused = stage_q[SPARE_LSB +: SPARE_W];
  assign commit  = ctl_wr & prog_en & (ctl_data[CTL_W-1 -: 4] == CMD_COMMIT);
  assign col_idx = ctl_data[QUAD_W-1:0];

  always_comb begin
    stage_d = col_wr ? col_data : stage_q;
    lvl_d   = lvl_q;
    s0_d    = s0_q;
    s1_d    = s1_q;
    glue_d  = glue_q;
    if (commit) begin
      for (int q = 0; q < NUM_QUADS; q++) begin
        lvl_d[q][col_idx] = stage_q[q];
        s0_d[q][col_idx]  = stage_q[SEL0_LSB + q];
        s1_d[q][col_idx]  = stage_q[SEL1_LSB + q];
      end
      glue_d[col_idx] = stage_q[GLUE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      lvl_q   <= '1;
      s0_q    <= '0;
      s1_q    <= '0;
      glue_q  <= '1;
    end else begin
      stage_q <= stage_d;
      lvl_q   <= lvl_d;
      s0_q    <= s0_d;
      s1_q    <= s1_d;
      glue_q  <= glue_d;
    end
  end

  assign lvl_tab  = lvl_q;
  assign sel0_tab = s0_q;
  assign sel1_tab = s1_q;
  assign glue_tab = glue_q;
endmodule

// File: rtl/trig_quad_match.sv
module trig_quad_match
  import trig_pkg::*;
(
  input  qset_t              tab,
  input  logic [PROBE_W-1:0] probes,
  output logic               hit
);
  logic [NUM_QUADS-1:0] quad_bit;

  for (genvar q = 0; q < NUM_QUADS; q++) begin : g_quad
    assign quad_bit[q] = tab[q][probes[q*QUAD_W +: QUAD_W]];
  end

  assign hit = &quad_bit;
endmodule

// File: rtl/trig_edge_glue.sv
module trig_edge_glue
  import trig_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  smp_en,
  input  logic  cur0,
  input  logic  cur1,
  input  glue_t glue_tab,
  output logic  edge_hit
);
  logic prev0_q, prev0_d, prev1_q, prev1_d;
  logic [GLUE_IW-1:0] glue_idx;

  always_comb begin
    prev0_d = prev0_q;
    prev1_d = prev1_q;
    if (smp_en) begin
      prev0_d = cur0;
      prev1_d = cur1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev0_q <= 1'b0;
      prev1_q <= 1'b0;
    end else begin
      prev0_q <= prev0_d;
      prev1_q <= prev1_d;
    end
  end

  assign glue_idx = {prev1_q, cur1, prev0_q, cur0};
  assign edge_hit = glue_tab[glue_idx];
endmodule

// File: rtl/quad_lut_trigger.sv
module quad_lut_trigger
  import trig_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PROBE_W-1:0] probes,
  input  logic               smp_en,
  input  logic               arm,
  input  logic               prog_en,
  input  logic               col_wr,
  input  logic [COL_W-1:0]   col_data,
  input  logic               ctl_wr,
  input  logic [CTL_W-1:0]   ctl_data,
  output logic               trig
);
  qset_t lvl_tab, sel0_tab, sel1_tab;
  glue_t glue_tab;
  qset_t set_tab [NUM_SETS];
  logic [NUM_SETS-1:0] set_hit;
  logic edge_hit;
  logic trig_q, trig_d;

  trig_lut_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_en  (prog_en),
    .col_wr   (col_wr),
    .col_data (col_data),
    .ctl_wr   (ctl_wr),
    .ctl_data (ctl_data),
    .lvl_tab  (lvl_tab),
    .sel0_tab (sel0_tab),
    .sel1_tab (sel1_tab),
    .glue_tab (glue_tab)
  );

  assign set_tab[0] = lvl_tab;
  assign set_tab[1] = sel0_tab;
  assign set_tab[2] = sel1_tab;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    trig_quad_match u_match (
      .tab    (set_tab[s]),
      .probes (probes),
      .hit    (set_hit[s])
    );
  end

  trig_edge_glue u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_en   (smp_en),
    .cur0     (set_hit[1]),
    .cur1     (set_hit[2]),
    .glue_tab (glue_tab),
    .edge_hit (edge_hit)
  );

  always_comb begin
    trig_d = trig_q;
    if (arm)
      trig_d = 1'b0;
    else if (smp_en && !prog_en && set_hit[0] && edge_hit)
      trig_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_d;
  end

  assign trig = trig_q;
endmodule

// File: rtl/quad_lut_trigger_chk.sv
module quad_lut_trigger_chk
  import trig_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  smp_en,
  input logic  arm,
  input logic  prog_en,
  input logic  ctl_wr,
  input logic  trig,
  input glue_t glue_tab,
  input qset_t lvl_tab
);
  assert_trig_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !arm) |=> trig);

  assert_arm_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !trig);

  assert_prog_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && !arm && !trig) |=> !trig);

  assert_set_needs_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig) |-> $past(smp_en));

  assert_commit_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !prog_en) |=> ($stable(glue_tab) && $stable(lvl_tab)));
endmodule

bind quad_lut_trigger quad_lut_trigger_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_en   (smp_en),
  .arm      (arm),
  .prog_en  (prog_en),
  .ctl_wr   (ctl_wr),
  .trig     (trig),
  .glue_tab (glue_tab),
  .lvl_tab  (lvl_tab)
);

// File: tb/quad_lut_trigger_test.sv
module quad_lut_trigger_test;
  localparam int CLK_P = 10;

  logic        clk, rst_n, smp_en, arm, prog_en, col_wr, ctl_wr, trig;
  logic [15:0] probes, col_data;
  logic [7:0]  ctl_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [3:0][15:0] m_lvl, m_s0, m_s1;
  logic [15:0] m_glue;
  bit m_p0, m_p1, m_trig;
  logic [15:0] lfsr = 16'hACE1;

  quad_lut_trigger uut (
    .clk(clk), .rst_n(rst_n), .probes(probes), .smp_en(smp_en), .arm(arm),
    .prog_en(prog_en), .col_wr(col_wr), .col_data(col_data),
    .ctl_wr(ctl_wr), .ctl_data(ctl_data), .trig(trig)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] vm_entry(int q, logic [15:0] val, logic [15:0] msk);
    logic [15:0] e;
    for (int j = 0; j < 16; j++) begin
      e[j] = 1'b1;
      for (int k = 0; k < 4; k++)
        if (msk[q*4+k] && (val[q*4+k] != ((j >> k) & 1))) e[j] = 1'b0;
    end
    return e;
  endfunction

  function automatic bit qand(logic [3:0][15:0] t, logic [15:0] p);
    bit r = 1'b1;
    for (int q = 0; q < 4; q++) r &= t[q][p[q*4 +: 4]];
    return r;
  endfunction

  function automatic logic [15:0] next_noise();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr;
  endfunction

  task automatic check(bit got, bit exp, string req, string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, got, exp);
    end
  endtask

  task automatic set_level(logic [15:0] val, logic [15:0] msk);
    for (int q = 0; q < 4; q++) m_lvl[q] = vm_entry(q, val, msk);
  endtask

  task automatic set_sel(int which, int probe);
    for (int q = 0; q < 4; q++) begin
      if (which == 0) m_s0[q] = (probe < 0) ? 16'h0 : vm_entry(q, 16'(1 << probe), 16'(1 << probe));
      else            m_s1[q] = (probe < 0) ? 16'h0 : vm_entry(q, 16'(1 << probe), 16'(1 << probe));
    end
  endtask

  // glue: rise/fall selection per selector, ORed together
  task automatic set_glue(bit r0, bit f0, bit r1, bit f1);
    for (int i = 0; i < 16; i++) begin
      bit c0 = i[0], p0 = i[1], c1 = i[2], p1 = i[3];
      m_glue[i] = (r0 & !p0 & c0) | (f0 & p0 & !c0) | (r1 & !p1 & c1) | (f1 & p1 & !c1);
    end
  endtask

  // R7: column i carries bit i of every table; low-byte bits 7..5 get junk
  task automatic program_tables();
    prog_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      logic [15:0] col;
      for (int q = 0; q < 4; q++) begin
        col[q]      = m_lvl[q][i];
        col[8 + q]  = m_s0[q][i];
        col[12 + q] = m_s1[q][i];
      end
      col[4]   = m_glue[i];
      col[7:5] = 3'(i + 5);
      col_wr = 1'b1; col_data = col;
      @(negedge clk);
      col_wr = 1'b0; ctl_wr = 1'b1; ctl_data = 8'h30 | 8'(i);
      @(negedge clk);
      ctl_wr = 1'b0;
    end
    prog_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic sample(logic [15:0] p, bit do_arm, bit in_prog, string req);
    bit c0, c1, hit;
    if (do_arm) begin
      arm = 1'b1; probes = ~p;
      @(negedge clk);
      arm = 1'b0;
      m_trig = 1'b0;
    end
    prog_en = in_prog;
    smp_en = 1'b1; probes = p;
    @(negedge clk);
    smp_en = 1'b0; prog_en = 1'b0;
    c0  = qand(m_s0, p);
    c1  = qand(m_s1, p);
    hit = qand(m_lvl, p) & m_glue[{m_p1, c1, m_p0, c0}];
    if (!in_prog) m_trig = m_trig | hit;
    m_p0 = c0; m_p1 = c1;
    check(trig, m_trig, req, $sformatf("probes=%04h", p));
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; smp_en = 0; arm = 0; prog_en = 0; col_wr = 0; ctl_wr = 0;
    probes = '0; col_data = '0; ctl_data = '0;
    m_lvl = '1; m_s0 = '0; m_s1 = '0; m_glue = '1; m_p0 = 0; m_p1 = 0; m_trig = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(trig, 1'b0, "R1", "reset state");
    repeat (3) @(negedge clk);
    check(trig, 1'b0, "R1", "idle after reset");
    sample(16'h1234, 1'b0, 1'b0, "R1");

    // R2: 8 masked probes swept exhaustively, others noise
    set_level(16'hA5C3, 16'h0FF0); set_sel(0, -1); set_sel(1, -1); m_glue = '1;
    program_tables();
    for (int i = 0; i < 256; i++)
      sample((next_noise() & 16'hF00F) | 16'(i << 4), 1'b1, 1'b0, "R2");
    set_level(16'h8001, 16'h8421);
    program_tables();
    for (int i = 0; i < 64; i++) begin
      logic [15:0] p = next_noise() & 16'h7BDE;
      p |= {i[3], 4'h0, i[2], 4'h0, i[1], 4'h0, i[0]};
      sample(p, 1'b1, 1'b0, "R2");
    end

    // R3: rise on probe 5, fall on probe 12
    set_level(16'h0, 16'h0); set_sel(0, 5); set_sel(1, 12); set_glue(1, 0, 0, 1);
    program_tables();
    for (int i = 0; i < 300; i++) sample(next_noise(), 1'b1, 1'b0, "R3");
    // R3: both edges ORed on one selector (probe 2)
    set_sel(0, 2); set_sel(1, -1); set_glue(1, 1, 0, 0);
    program_tables();
    for (int i = 0; i < 200; i++) sample(next_noise(), 1'b1, 1'b0, "R3");

    // R4: level on quad 0 plus rise on probe 9
    set_level(16'h000A, 16'h000F); set_sel(0, 9); set_glue(1, 0, 0, 0);
    program_tables();
    for (int i = 0; i < 200; i++) begin
      logic [15:0] p = next_noise();
      if (i % 3 == 0) p[3:0] = 4'hA;
      sample(p, 1'b1, 1'b0, "R4");
    end

    // R9/R6: samples during programming mode update history but never set trig
    sample(16'h000A, 1'b1, 1'b0, "R6");
    sample(16'h020A, 1'b1, 1'b1, "R9");
    sample(16'h020A, 1'b1, 1'b0, "R6");
    sample(16'h000A, 1'b1, 1'b0, "R6");
    sample(16'h020A, 1'b1, 1'b0, "R6");
    for (int i = 0; i < 40; i++) sample(next_noise() | 16'h000A, 1'b1, (i % 2) == 1, "R6");

    // R8: ignored commits, then behaviour must match unchanged tables
    col_wr = 1'b1; col_data = 16'h0000;
    @(negedge clk);
    col_wr = 1'b0;
    for (int i = 0; i < 16; i++) begin
      ctl_wr = 1'b1; ctl_data = 8'h30 | 8'(i); prog_en = 1'b0;
      @(negedge clk);
      ctl_data = 8'h20 | 8'(i); prog_en = 1'b1;
      @(negedge clk);
      ctl_data = 8'hB0 | 8'(i);
      @(negedge clk);
      ctl_wr = 1'b0; prog_en = 1'b0;
    end
    for (int i = 0; i < 80; i++) begin
      logic [15:0] p = next_noise();
      if (i % 2 == 0) p[3:0] = 4'hA;
      sample(p, 1'b1, 1'b0, "R8");
    end

    // R5: sticky flag, arm clears, arm beats a matching sample
    set_level(16'h00F0, 16'h00F0); set_sel(0, -1); m_glue = '1;
    program_tables();
    sample(16'h00F0, 1'b1, 1'b0, "R5");
    sample(16'h0000, 1'b0, 1'b0, "R5");
    sample(16'h1200, 1'b0, 1'b0, "R5");
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    check(trig, 1'b0, "R5", "arm alone clears");
    sample(16'h00F0, 1'b0, 1'b0, "R5");
    arm = 1'b1; smp_en = 1'b1; probes = 16'h00F0;
    @(negedge clk);
    arm = 1'b0; smp_en = 1'b0;
    check(trig, 1'b0, "R5", "arm wins over match");
    m_trig = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule